// File: doc/BRIEF.md
# Strobe-Framed Serial PCM Port

This block moves one PCM byte in each direction per frame between a parallel internal side and a serial line shared with an external controller. The controller raises a strobe to open a timeslot. While the strobe is high, received bits are taken from the serial input on falling bit-clock edges. Transmitted bits are put on the serial output on rising bit-clock edges, most significant bit first. Outside the timeslot the output enable is low, so the pad cell holds the line in high impedance.

The port has two modes. In synchronous mode it follows the controller's bit clock and has no frame of latency: the byte offered for a frame goes out in that frame, and a received byte is reported as soon as its eighth bit is in. In asynchronous mode it derives its own bit clock from the 4.096 MHz master clock, at 128 kb/s or 256 kb/s. It then places a one-frame holding stage in each direction. When no transmit path is selected, the timeslot carries a fixed quiet code. All logic runs on the master clock. The serial inputs are brought in through synchronizer flops, and bit-clock edges become single-cycle enables.

Top module: `strobe_pcm_port`

## Requirements
- R1: While `rst_n` is low, and afterwards until a strobe arrives, `dout_oe` and `rx_valid` are 0 and `rx_byte` is 0.
- R2: `dout_oe` is 1 while `strobe` is high, delayed by SYNC_STAGES master cycles, and 0 otherwise; the pad drives high impedance when it is 0.
- R3: Received bits are sampled on falling bit-clock edges inside the window, first bit into `rx_byte[7]`.
- R4: The first rising bit-clock edge inside a window drives bit 7 of the outgoing byte on `dout`; each later rising edge moves to the next lower bit.
- R5: If `tx_path_en` is 0 at the first rising edge of a window, every bit of that window is the quiet code (parameter QUIET, default 8'hFF); reception is unaffected.
- R6: With `mode_async`=0, the `tx_byte` value present at the first rising edge is sent in the same window, and `rx_valid` pulses one master cycle after the eighth falling edge of the same window.
- R7: With `mode_async`=1, window N sends the `tx_byte` value sampled at the start of window N-1 (the first window after reset sends QUIET), and a byte completed in window N is reported on `rx_byte` with `rx_valid` at the start of window N+1.
- R8: With `mode_async`=1, the internal bit period is 16 master cycles for `clk_sel`=01 and 32 master cycles for 00, 10 and 11. Its phase restarts with each strobe, so the first rising edge falls at the start of the window, and `ext_bclk` is ignored.
- R9: With `mode_async`=0, the value of `clk_sel` has no effect on the data moved.
- R10: `rx_valid` is a one-cycle pulse. A window that closes before eight falling edges produces no pulse: none in that window in synchronous mode, and none at the next window in asynchronous mode. Later frames are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (4.096 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_async | input | 1 | 0: external bit clock, 1: internal bit clock with one-frame delay |
| clk_sel | input | 2 | Clock-rate select |
| ext_bclk | input | 1 | External bit clock (synchronous mode) |
| strobe | input | 1 | Timeslot strobe, active high |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for the serial output pad |
| tx_byte | input | 8 | Byte to transmit |
| tx_path_en | input | 1 | Transmit path selected; 0 sends the quiet code |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_byte` |

## Verification
The bench builds the port with its defaults: an 8-bit byte, a 4096 kHz master clock and async rates of 128 and 256 kb/s, which gives bit periods of 32 and 16 master cycles. At these sizes a synchronous frame takes under a hundred cycles, so all 256 byte values can be swept in both directions. Every `clk_sel` code can also be run in both modes. Asynchronous runs chain a dozen frames, with the path toggled and a short window in the middle, so the one-frame carry of both the held transmit byte and the pending received byte is checked across aborts.

// File: rtl/spcm_pkg.sv
package spcm_pkg;

  typedef enum logic {
    MODE_EXT_CLK = 1'b0,
    MODE_INT_CLK = 1'b1
  } spcm_mode_e;

  // clk_sel code that picks the faster internal bit rate
  localparam logic [1:0] FAST_RATE_CODE = 2'b01;

  function automatic int half_period(input int mclk_khz, input int rate_khz);
    return mclk_khz / (2 * rate_khz);
  endfunction

endpackage

// File: rtl/spcm_sync_bits.sv
module spcm_sync_bits #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spcm_bitclk.sv
// Turns either the synchronized external bit clock or an internal divider
// into single-cycle rise/fall enables, gated by the active window.
module spcm_bitclk #(
  parameter int HALF_LO = 16,
  parameter int HALF_HI = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_en,
  input  logic fast,
  input  logic bclk_s,
  input  logic win_active,
  output logic bit_rise,
  output logic bit_fall
);

  localparam int CW = $clog2(2 * HALF_LO);
  localparam logic [CW-1:0] LAST_LO = CW'(2 * HALF_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(2 * HALF_HI - 1);
  localparam logic [CW-1:0] MID_LO  = CW'(HALF_LO);
  localparam logic [CW-1:0] MID_HI  = CW'(HALF_HI);

  logic [CW-1:0] cnt_q, cnt_n, last_c, mid_c;
  logic          bclk_d_q;

  always_comb begin
    last_c = fast ? LAST_HI : LAST_LO;
    mid_c  = fast ? MID_HI : MID_LO;
    cnt_n  = '0;
    // R8: divider runs only inside a window, so its phase restarts per strobe
    if (async_en && win_active) begin
      cnt_n = (cnt_q == last_c) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      bclk_d_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      bclk_d_q <= bclk_s;
    end
  end

  always_comb begin
    if (async_en) begin
      bit_rise = win_active && (cnt_q == '0);
      bit_fall = win_active && (cnt_q == mid_c);
    end else begin
      bit_rise = win_active && bclk_s && !bclk_d_q;
      bit_fall = win_active && !bclk_s && bclk_d_q;
    end
  end

endmodule

// File: rtl/spcm_tx.sv
module spcm_tx #(
  parameter int           W     = 8,
  parameter logic [W-1:0] QUIET = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         win_active,
  input  logic         bit_rise,
  input  logic [W-1:0] load_byte,
  output logic         frame_start,
  output logic         dout_bit
);

  localparam int CNTW = $clog2(W + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(W);

  logic [W-1:0]    sh_q, sh_n;
  logic [CNTW-1:0] cnt_q, cnt_n;

  assign frame_start = win_active && bit_rise && (cnt_q == '0);

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (!win_active) begin
      sh_n  = QUIET;
      cnt_n = '0;
    end else if (bit_rise) begin
      if (cnt_q == '0) begin
        // R4: first rising edge presents the MSB
        sh_n  = load_byte;
        cnt_n = CNTW'(1);
      end else if (cnt_q != FULL) begin
        sh_n  = {sh_q[W-2:0], 1'b0};
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= QUIET;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  assign dout_bit = sh_q[W-1];

endmodule

// File: rtl/spcm_rx.sv
module spcm_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         win_active,
  input  logic         bit_fall,
  input  logic         din_s,
  output logic         done,
  output logic [W-1:0] done_byte
);

  localparam int CNTW = $clog2(W + 1);
  localparam logic [CNTW-1:0] LASTB = CNTW'(W - 1);
  localparam logic [CNTW-1:0] FULL  = CNTW'(W);

  logic [W-2:0]    sh_q, sh_n;
  logic [CNTW-1:0] cnt_q, cnt_n;

  // R3: eighth falling edge completes the byte, first bit lands in the MSB
  assign done      = win_active && bit_fall && (cnt_q == LASTB);
  assign done_byte = {sh_q, din_s};

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (!win_active) begin
      cnt_n = '0;  // R10: a short window drops its partial byte
    end else if (bit_fall && (cnt_q != FULL)) begin
      sh_n  = {sh_q[W-3:0], din_s};
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/strobe_pcm_port.sv
module strobe_pcm_port
  import spcm_pkg::*;
#(
  parameter int           W           = 8,
  parameter logic [W-1:0] QUIET       = '1,
  parameter int           MCLK_KHZ    = 4096,
  parameter int           RATE_LO_KHZ = 128,
  parameter int           RATE_HI_KHZ = 256,
  parameter int           SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_async,
  input  logic [1:0]   clk_sel,
  input  logic         ext_bclk,
  input  logic         strobe,
  input  logic         din,
  output logic         dout,
  output logic         dout_oe,
  input  logic [W-1:0] tx_byte,
  input  logic         tx_path_en,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid
);

  localparam int HALF_LO = half_period(MCLK_KHZ, RATE_LO_KHZ);
  localparam int HALF_HI = half_period(MCLK_KHZ, RATE_HI_KHZ);

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  spcm_mode_e mode;
  logic       async_en, fast;
  assign mode     = spcm_mode_e'(mode_async);
  assign async_en = (mode == MODE_INT_CLK);
  assign fast     = (clk_sel == FAST_RATE_CODE);  // R8, R9

  logic bclk_s, stb_s, din_s;
  spcm_sync_bits #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_i),
    .d    ({ext_bclk, strobe, din}),
    .q    ({bclk_s, stb_s, din_s})
  );

  logic bit_rise, bit_fall;
  spcm_bitclk #(.HALF_LO(HALF_LO), .HALF_HI(HALF_HI)) u_bitclk (
    .clk       (clk),
    .rst_n     (rst_i),
    .async_en  (async_en),
    .fast      (fast),
    .bclk_s    (bclk_s),
    .win_active(stb_s),
    .bit_rise  (bit_rise),
    .bit_fall  (bit_fall)
  );

  logic [W-1:0] hold_q, hold_n, load_byte;
  logic         frame_start, tx_bit;

  // R5: quiet code replaces the byte; R6/R7: current or held byte
  assign load_byte = !tx_path_en ? QUIET : (async_en ? hold_q : tx_byte);

  spcm_tx #(.W(W), .QUIET(QUIET)) u_tx (
    .clk        (clk),
    .rst_n      (rst_i),
    .win_active (stb_s),
    .bit_rise   (bit_rise),
    .load_byte  (load_byte),
    .frame_start(frame_start),
    .dout_bit   (tx_bit)
  );

  logic         rx_done;
  logic [W-1:0] rx_done_byte;
  spcm_rx #(.W(W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_i),
    .win_active(stb_s),
    .bit_fall  (bit_fall),
    .din_s     (din_s),
    .done      (rx_done),
    .done_byte (rx_done_byte)
  );

  logic [W-1:0] rxb_q, rxb_n, pend_q, pend_n;
  logic         rxv_q, rxv_n, pv_q, pv_n;

  always_comb begin
    hold_n = hold_q;
    rxb_n  = rxb_q;
    rxv_n  = 1'b0;
    pend_n = pend_q;
    pv_n   = pv_q;
    if (async_en) begin
      // R7: one frame of delay in both directions
      if (frame_start) begin
        hold_n = tx_byte;
        if (pv_q) begin
          rxv_n = 1'b1;
          rxb_n = pend_q;
          pv_n  = 1'b0;
        end
      end
      if (rx_done) begin
        pend_n = rx_done_byte;
        pv_n   = 1'b1;
      end
    end else if (rx_done) begin
      // R6: report in the same window
      rxv_n = 1'b1;
      rxb_n = rx_done_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hold_q <= QUIET;
      rxb_q  <= '0;
      rxv_q  <= 1'b0;
      pend_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      hold_q <= hold_n;
      rxb_q  <= rxb_n;
      rxv_q  <= rxv_n;
      pend_q <= pend_n;
      pv_q   <= pv_n;
    end
  end

  assign dout     = tx_bit;
  assign dout_oe  = stb_s;  // R2
  assign rx_byte  = rxb_q;
  assign rx_valid = rxv_q;

endmodule

// File: rtl/spcm_port_chk.sv
module spcm_port_chk #(
  parameter int           W           = 8,
  parameter logic [W-1:0] QUIET       = '1,
  parameter int           SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic strobe,
  input logic tx_path_en,
  input logic dout,
  input logic dout_oe,
  input logic rx_valid
);

  localparam bit QUIET_UNIFORM = (QUIET == {W{QUIET[0]}});

  // path has been off since before the current window opened
  logic off_clean_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          off_clean_q <= 1'b0;
    else if (tx_path_en) off_clean_q <= 1'b0;
    else if (!dout_oe)   off_clean_q <= 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!dout_oe && !rx_valid));

  a_r2_oe_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe, SYNC_STAGES) |-> !dout_oe);

  a_r3_valid_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(strobe, SYNC_STAGES + 1));

  a_r5_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
    (QUIET_UNIFORM && dout_oe && off_clean_q) |-> (dout == QUIET[0]));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

bind strobe_pcm_port spcm_port_chk #(
  .W(W), .QUIET(QUIET), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strobe    (strobe),
  .tx_path_en(tx_path_en),
  .dout      (dout),
  .dout_oe   (dout_oe),
  .rx_valid  (rx_valid)
);

// File: tb/tb_strobe_pcm_port.sv
module tb_strobe_pcm_port;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, mode_async, ext_bclk, strobe, din, tx_path_en;
  logic [1:0] clk_sel;
  logic [7:0] tx_byte;
  logic       dout, dout_oe, rx_valid;
  logic [7:0] rx_byte;

  int total = 0;
  int bad   = 0;
  int vcount = 0;
  logic [7:0] vbyte = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_pcm_port dut (
    .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .clk_sel(clk_sel),
    .ext_bclk(ext_bclk), .strobe(strobe), .din(din), .dout(dout),
    .dout_oe(dout_oe), .tx_byte(tx_byte), .tx_path_en(tx_path_en),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      vcount = vcount + 1;
      vbyte  = rx_byte;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic [1:0] cs);
    rst_n = 1'b0; mode_async = m; clk_sel = cs;
    strobe = 1'b0; ext_bclk = 1'b0; din = 1'b0;
    tx_byte = 8'h00; tx_path_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe in reset", int'(dout_oe), 0);
    chk("R1 valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 rx_byte after reset", int'(rx_byte), 0);
    chk("R1 oe after reset", int'(dout_oe), 0);
  endtask

  task automatic frame_sync(input logic [7:0] txv, input logic [7:0] rxv,
                            input int nbits, output logic [7:0] got);
    got = 8'h00;
    vcount = 0;
    tx_byte = txv;
    strobe = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      ext_bclk = 1'b1;
      din = rxv[7-k];
      repeat (4) @(negedge clk);
      got[7-k] = dout;
      if (k == 0) chk("R2 oe inside window", int'(dout_oe), 1);
      ext_bclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    strobe = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 oe after window", int'(dout_oe), 0);
  endtask

  task automatic frame_async(input logic [7:0] txv, input logic [7:0] rxv,
                             input int nbits, input int per,
                             output logic [7:0] got);
    got = 8'h00;
    vcount = 0;
    tx_byte = txv;
    strobe = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      din = rxv[7-k];
      ext_bclk = k[0];  // R8: must be ignored
      @(negedge clk);
      got[7-k] = dout;
      repeat (per - 1) @(negedge clk);
    end
    strobe = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 oe after window", int'(dout_oe), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;

    // synchronous mode: every byte value, both directions (R3 R4 R6)
    do_reset(1'b0, 2'b00);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] rxv;
      rxv = 8'((v * 37 + 11) & 255);
      frame_sync(8'(v), rxv, 8, got);
      chk("R4 R6 sync tx byte", int'(got), v);
      chk("R3 R6 sync rx count", vcount, 1);
      chk("R3 R6 sync rx byte", int'(vbyte), int'(rxv));
    end

    // R5: path off sends quiet code, reception still works
    tx_path_en = 1'b0;
    frame_sync(8'h12, 8'h6C, 8, got);
    chk("R5 quiet code", int'(got), 8'hFF);
    chk("R5 rx unaffected", int'(vbyte), 8'h6C);
    tx_path_en = 1'b1;

    // R10: short window gives no pulse, next frame normal
    frame_sync(8'h0F, 8'hC3, 5, got);
    chk("R10 abort no valid", vcount, 0);
    frame_sync(8'h81, 8'h7E, 8, got);
    chk("R10 after abort tx", int'(got), 8'h81);
    chk("R10 after abort rx", int'(vbyte), 8'h7E);
    chk("R10 after abort count", vcount, 1);

    // R9: clk_sel irrelevant in synchronous mode
    for (int cs = 1; cs < 4; cs++) begin
      do_reset(1'b0, 2'(cs));
      frame_sync(8'hA5, 8'h3C, 8, got);
      chk("R9 sync tx any clk_sel", int'(got), 8'hA5);
      chk("R9 sync rx any clk_sel", int'(vbyte), 8'h3C);
    end

    // asynchronous mode, every clk_sel code (R7 R8 R10 R5)
    for (int cs = 0; cs < 4; cs++) begin
      int per;
      logic [7:0] prev_tx, prev_rx;
      bit prev_ok;
      per = (cs == 1) ? 16 : 32;
      do_reset(1'b1, 2'(cs));
      prev_tx = 8'hFF;
      prev_rx = 8'h00;
      prev_ok = 1'b0;
      for (int i = 0; i < 12; i++) begin
        logic [7:0] txv, rxv;
        int nb;
        logic pth;
        txv = 8'((i * 53 + 7 + cs) & 255);
        rxv = 8'((i * 29 + 200 - cs) & 255);
        nb  = (i == 5) ? 3 : 8;
        pth = (i % 4 != 2);
        tx_path_en = pth;
        frame_async(txv, rxv, nb, per, got);
        if (nb == 8) begin
          chk(pth ? "R7 R8 async tx delayed" : "R5 async quiet",
              int'(got), pth ? int'(prev_tx) : 8'hFF);
        end
        chk("R7 R10 async rx count", vcount, prev_ok ? 1 : 0);
        if (prev_ok) chk("R7 R8 async rx delayed", int'(vbyte), int'(prev_rx));
        prev_tx = txv;
        prev_rx = rxv;
        prev_ok = (nb == 8);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule